// File: doc/BRIEF.md
# Indexed Register Access Bridge

This block lets a host with only four narrow direct registers reach a 16-bit internal space of byte-wide locations. The host loads a low index byte and a high index byte, then moves bytes through a single data register. The bridge sends each data access to the internal location the combined index selects. Optionally, the index steps forward by one after every data access, so a whole table can be streamed through the data register without reloading the index.

Behind the bridge there are four regions. A general control bank holds plain read/write bytes. A clock-control bank has two bytes whose bit 1 is a read-only lock flag. A cursor colour palette stores fifteen red/green/blue triples and reads back in reversed entry order. A 1 KiB cursor pattern RAM completes the space. Every other index is unmapped.

The host port is plain and single-cycle: one access per cycle while `host_sel` is high, with no back-pressure. Each read returns its data on the following cycle, flagged by a one-cycle `host_rvalid` pulse.

Top module: `idx_reg_bridge`

## Requirements
- R1: After reset the index is 0x0000, auto-increment is off, every internal location reads 0x00, and `host_rvalid` is low.
- R2: Host register 0 holds the index low byte, register 1 holds the high byte, and register 3 is the control register. Only its bit 0 (auto-increment enable) is stored, and its other bits read 0. All three read back what was written.
- R3: Host register 2 reads or writes the internal byte at index {high,low}. Read data appears on `host_rdata` one cycle after the read, with `host_rvalid` high for exactly that cycle. `host_rvalid` is low in every other cycle.
- R4: Only bits 7:0 of `host_wdata` are used. Bits 31:8 of `host_rdata` always read 0.
- R5: With auto-increment on, every data-register read or write advances the 16-bit index by one after the access. The count carries from the low byte into the high byte and wraps from 0xFFFF to 0x0000.
- R6: With auto-increment off, data accesses leave the index unchanged.
- R7: Indices 0x000 through 0x02C are plain read/write control bytes.
- R8: Indices 0x303 through 0x32F hold palette entry n (0..14), component c (0 red, 1 green, 2 blue) at 0x303+3n+c. A read of that index returns the stored component c of entry 14−n.
- R9: Indices 0x400 through 0x7FF are a read/write cursor pattern RAM.
- R10: Indices 0x200 through 0x215 are clock-control bytes. Bit 1 of index 0x200 reads `lock_in[0]` and bit 1 of index 0x20D reads `lock_in[1]`. Host writes cannot change either bit. All other bits in the bank are read/write.
- R11: A write to an unmapped index changes nothing, and a read of one returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access this cycle |
| host_wr | input | 1 | 1 write, 0 read |
| host_addr | input | 2 | Host register: 0 index low, 1 index high, 2 data, 3 control |
| host_wdata | input | 32 | Write data (bits 7:0 used) |
| lock_in | input | 2 | Lock status flags for the two clock-control bytes |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid pulse |

## Verification
The hardest cases are the index carry across the byte boundary and the wrap at 0xFFFF. Neither occurs during ordinary table streaming. The stimulus therefore loads indices of 0x03FF and 0xFFFF directly, then issues one auto-incrementing data access, and reads both index bytes back through the port. The reversed palette read-back only shows up when all fifteen triples hold distinct values. The bench streams 45 distinct bytes with auto-increment on and reads the whole palette back. The lock bits are exercised by writing all ones and all zeros while `lock_in` holds different values.

// File: rtl/irb_pkg.sv
package irb_pkg;
  typedef enum logic [1:0] {
    HREG_IDX_LO = 2'd0,
    HREG_IDX_HI = 2'd1,
    HREG_DATA   = 2'd2,
    HREG_CTRL   = 2'd3
  } host_reg_e;

  localparam int IDX_W        = 16;
  localparam int BYTE_W       = 8;
  localparam int HOST_W       = 32;

  localparam int CTRL_BASE    = 'h000;
  localparam int CTRL_DEPTH   = 45;
  localparam int CLK_BASE     = 'h200;
  localparam int CLK_DEPTH    = 22;
  localparam int CLK_LOCK_A   = 'h00;
  localparam int CLK_LOCK_B   = 'h0D;
  localparam int PAL_BASE     = 'h303;
  localparam int PAL_ENTRIES  = 15;
  localparam int PAT_BASE     = 'h400;
  localparam int PAT_DEPTH    = 1024;
endpackage

// File: rtl/irb_index.sv
module irb_index
  import irb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ctrl,
  input  logic              data_acc,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [IDX_W-1:0]  idx,
  output logic              autoinc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      autoinc <= 1'b0;
    end else begin
      if (wr_lo)
        idx[BYTE_W-1:0] <= wbyte;
      else if (wr_hi)
        idx[IDX_W-1:BYTE_W] <= wbyte;
      else if (data_acc && autoinc)
        idx <= idx + 1'b1;
      if (wr_ctrl)
        autoinc <= wbyte[0];
    end
  end

  // R5: the step after a data access, carry and wrap included
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && autoinc) |=> (idx == $past(idx) + 16'd1));

  // R6: no stepping while auto-increment is off
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !autoinc && !wr_lo && !wr_hi) |=> $stable(idx));
endmodule

// File: rtl/irb_bank.sv
module irb_bank
  import irb_pkg::*;
#(
  parameter int BASE     = 0,
  parameter int DEPTH    = 16,
  parameter bit HAS_LOCK = 1'b0,
  parameter int LOCK_A   = 0,
  parameter int LOCK_B   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [1:0]        lock,
  output logic              hit,
  output logic [BYTE_W-1:0] rbyte
);
  localparam int OFF_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  rel;
  logic [OFF_W-1:0]  off;
  logic [BYTE_W-1:0] raw;
  logic [BYTE_W-1:0] wmasked;

  assign rel = idx - IDX_W'(BASE);
  assign off = rel[OFF_W-1:0];
  assign hit = (idx >= IDX_W'(BASE)) && (rel < IDX_W'(DEPTH));
  assign raw = hit ? mem[off] : '0;

  generate
    if (HAS_LOCK) begin : g_lock
      logic is_a, is_b;
      assign is_a = (off == OFF_W'(LOCK_A));
      assign is_b = (off == OFF_W'(LOCK_B));
      assign wmasked = (is_a || is_b) ? (wbyte & 8'hFD) : wbyte;
      always_comb begin
        rbyte = raw;
        if (hit && is_a) rbyte[1] = lock[0];
        if (hit && is_b) rbyte[1] = lock[1];
      end
    end else begin : g_plain
      logic [1:0] unused_lock;
      assign unused_lock = lock;
      assign wmasked = wbyte;
      assign rbyte   = raw;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && hit) begin
      mem[off] <= wmasked;
    end
  end
endmodule

// File: rtl/irb_palette.sv
module irb_palette
  import irb_pkg::*;
#(
  parameter int BASE    = 'h303,
  parameter int ENTRIES = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              hit,
  output logic [BYTE_W-1:0] rbyte
);
  localparam int BYTES = ENTRIES * 3;
  localparam int PA_W  = $clog2(BYTES);

  logic [BYTE_W-1:0] mem [BYTES];
  logic [IDX_W-1:0]  rel;
  logic [IDX_W-1:0]  ent;
  logic [IDX_W-1:0]  comp;
  logic [IDX_W-1:0]  mirror;
  logic [PA_W-1:0]   waddr;
  logic [PA_W-1:0]   raddr;

  assign rel    = idx - IDX_W'(BASE);
  assign hit    = (idx >= IDX_W'(BASE)) && (rel < IDX_W'(BYTES));
  assign ent    = rel / 16'd3;
  assign comp   = rel % 16'd3;
  assign mirror = (IDX_W'(ENTRIES - 1) - ent) * 16'd3 + comp;
  assign waddr  = rel[PA_W-1:0];
  assign raddr  = mirror[PA_W-1:0];
  assign rbyte  = hit ? mem[raddr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
    end else if (we && hit) begin
      mem[waddr] <= wbyte;
    end
  end
endmodule

// File: rtl/idx_reg_bridge.sv
module idx_reg_bridge
  import irb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  input  logic [1:0]  lock_in,
  output logic [31:0] host_rdata,
  output logic        host_rvalid
);
  localparam int NB = 4;

  logic [IDX_W-1:0]  idx;
  logic              autoinc;
  logic [BYTE_W-1:0] wbyte;
  logic              data_acc, data_we, rd_req;
  logic [NB-1:0]     hits;
  logic [BYTE_W-1:0] bytes_rd [NB];
  logic [BYTE_W-1:0] space_rd;
  logic [BYTE_W-1:0] mux_rd;
  logic              unused_hi;

  assign wbyte     = host_wdata[BYTE_W-1:0];
  assign unused_hi = ^host_wdata[HOST_W-1:BYTE_W];
  assign data_acc  = host_sel && (host_addr == HREG_DATA);
  assign data_we   = data_acc && host_wr;
  assign rd_req    = host_sel && !host_wr;

  irb_index u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (host_sel && host_wr && (host_addr == HREG_IDX_LO)),
    .wr_hi    (host_sel && host_wr && (host_addr == HREG_IDX_HI)),
    .wr_ctrl  (host_sel && host_wr && (host_addr == HREG_CTRL)),
    .data_acc (data_acc),
    .wbyte    (wbyte),
    .idx      (idx),
    .autoinc  (autoinc)
  );

  irb_bank #(.BASE(CTRL_BASE), .DEPTH(CTRL_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(data_we), .idx(idx), .wbyte(wbyte),
    .lock(lock_in), .hit(hits[0]), .rbyte(bytes_rd[0])
  );

  irb_bank #(.BASE(CLK_BASE), .DEPTH(CLK_DEPTH), .HAS_LOCK(1'b1),
             .LOCK_A(CLK_LOCK_A), .LOCK_B(CLK_LOCK_B)) u_clk (
    .clk(clk), .rst_n(rst_n), .we(data_we), .idx(idx), .wbyte(wbyte),
    .lock(lock_in), .hit(hits[1]), .rbyte(bytes_rd[1])
  );

  irb_palette #(.BASE(PAL_BASE), .ENTRIES(PAL_ENTRIES)) u_pal (
    .clk(clk), .rst_n(rst_n), .we(data_we), .idx(idx), .wbyte(wbyte),
    .hit(hits[2]), .rbyte(bytes_rd[2])
  );

  irb_bank #(.BASE(PAT_BASE), .DEPTH(PAT_DEPTH)) u_pat (
    .clk(clk), .rst_n(rst_n), .we(data_we), .idx(idx), .wbyte(wbyte),
    .lock(lock_in), .hit(hits[3]), .rbyte(bytes_rd[3])
  );

  always_comb begin
    space_rd = '0;
    for (int b = 0; b < NB; b++) space_rd |= bytes_rd[b];
  end

  always_comb begin
    unique case (host_addr)
      HREG_IDX_LO: mux_rd = idx[BYTE_W-1:0];
      HREG_IDX_HI: mux_rd = idx[IDX_W-1:BYTE_W];
      HREG_DATA:   mux_rd = space_rd;
      default:     mux_rd = {{(BYTE_W-1){1'b0}}, autoinc};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= rd_req;
      if (rd_req) host_rdata <= {{(HOST_W-BYTE_W){1'b0}}, mux_rd};
    end
  end

  // R3: each read gives exactly one valid pulse on the next cycle
  a_r3_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> host_rvalid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !host_rvalid);
  // R11: unmapped data reads return zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && data_acc && (hits == '0)) |=> (host_rdata == 32'd0));
endmodule

// File: tb/idx_reg_bridge_test.sv
module idx_reg_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [1:0]  lock_in = 2'b00;
  logic [31:0] host_rdata;
  logic        host_rvalid;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  byte unsigned mdl [int];
  int           m_idx = 0;
  bit           m_ainc = 1'b0;

  idx_reg_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .lock_in(lock_in),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit mapped(int i);
    return (i <= 'h2C) || (i >= 'h200 && i <= 'h215) ||
           (i >= 'h303 && i <= 'h32F) || (i >= 'h400 && i <= 'h7FF);
  endfunction

  function automatic int get(int i);
    return mdl.exists(i) ? int'(mdl[i]) : 0;
  endfunction

  function automatic int space_read(int i);
    int v;
    if (i >= 'h303 && i <= 'h32F) begin
      int n = (i - 'h303) / 3;
      int c = (i - 'h303) % 3;
      return get('h303 + 3 * (14 - n) + c);
    end
    if (!mapped(i)) return 0;
    v = get(i);
    if (i == 'h200) v = (v & 'hFD) | (int'(lock_in[0]) << 1);
    if (i == 'h20D) v = (v & 'hFD) | (int'(lock_in[1]) << 1);
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one host cycle; compares outputs at the following falling edge
  task automatic op(input bit wr, input int a, input int d, input string tag);
    int exp = 0;
    if (!wr) begin
      case (a)
        0: exp = m_idx & 'hFF;
        1: exp = (m_idx >> 8) & 'hFF;
        2: exp = space_read(m_idx);
        default: exp = int'(m_ainc);
      endcase
    end else begin
      case (a)
        0: m_idx = (m_idx & 'hFF00) | (d & 'hFF);
        1: m_idx = (m_idx & 'h00FF) | ((d & 'hFF) << 8);
        2: if (mapped(m_idx)) mdl[m_idx] = byte'(d & 'hFF);
        default: m_ainc = d[0];
      endcase
    end
    host_sel = 1'b1; host_wr = wr; host_addr = a[1:0]; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
    if (a == 2 && m_ainc) m_idx = (m_idx + 1) & 'hFFFF;
    check({tag, " rvalid"}, int'(host_rvalid), int'(!wr));
    if (!wr) check(tag, int'(host_rdata), exp);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    check({tag, " idle rvalid"}, int'(host_rvalid), 0);
  endtask

  task automatic set_idx(input int i);
    op(1, 0, i & 'hFF, "R2 idx lo");
    op(1, 1, (i >> 8) & 'hFF, "R2 idx hi");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rvalid after reset", int'(host_rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    op(0, 0, 0, "R1 idx lo reset");
    op(0, 1, 0, "R1 idx hi reset");
    op(0, 3, 0, "R1 ctrl reset");
    op(0, 2, 0, "R1 loc0 reset");
    set_idx('h405); op(0, 2, 0, "R1 pattern reset");
    idle("R3");

    // R2 / R4: control register stores only bit 0, upper bits ignored
    op(1, 3, 'hFFFF_FFFE, "R2 ctrl");
    op(0, 3, 0, "R2 ctrl bit0 only");
    op(1, 3, 'h0000_0001, "R2 ctrl");
    op(0, 3, 0, "R2 ctrl readback");
    op(1, 3, 0, "R2 ctrl off");
    set_idx('h1234); op(0, 0, 0, "R2 lo readback"); op(0, 1, 0, "R2 hi readback");

    // R4 / R7: single control byte with junk in the upper bits
    set_idx('h0005);
    op(1, 2, 'hDEAD_BEA5, "R4 write");
    op(0, 2, 0, "R4 R7 readback");
    // R6: index unchanged after data accesses with auto-increment off
    op(0, 0, 0, "R6 idx lo held");

    // R5 / R7: stream the whole control bank
    op(1, 3, 1, "R5 enable");
    set_idx(0);
    for (int k = 0; k < 45; k++) op(1, 2, 'h10 + 3 * k, "R7 stream write");
    op(0, 0, 0, "R5 idx after stream");
    set_idx(0);
    for (int k = 0; k < 46; k++) op(0, 2, 0, "R7 stream read");

    // R5: carry and wrap
    set_idx('h03FF);
    op(0, 2, 0, "R5 carry read");
    op(0, 0, 0, "R5 carry lo"); op(0, 1, 0, "R5 carry hi");
    set_idx('hFFFF);
    op(1, 2, 'h77, "R11 write top");
    op(0, 0, 0, "R5 wrap lo"); op(0, 1, 0, "R5 wrap hi");
    set_idx('hFFFF); op(0, 2, 0, "R11 read top");

    // R8: palette, reversed read-back
    set_idx('h303);
    for (int k = 0; k < 45; k++) op(1, 2, 'h40 + k, "R8 pal write");
    set_idx('h303);
    for (int k = 0; k < 45; k++) op(0, 2, 0, "R8 pal read");

    // R9 / R11: pattern RAM edges and neighbours
    set_idx('h3FE);
    for (int k = 0; k < 4; k++) op(1, 2, 'hA0 + k, "R9 pat low edge write");
    set_idx('h7FE);
    for (int k = 0; k < 3; k++) op(1, 2, 'hC0 + k, "R9 pat high edge write");
    set_idx('h3FE);
    for (int k = 0; k < 4; k++) op(0, 2, 0, "R9 pat low edge read");
    set_idx('h7FE);
    for (int k = 0; k < 3; k++) op(0, 2, 0, "R9 R11 pat high edge read");

    // R10: lock bits
    op(1, 3, 0, "R6 disable");
    lock_in = 2'b01;
    set_idx('h200); op(1, 2, 'hFF, "R10 write ones");
    op(0, 2, 0, "R10 lock a set");
    op(1, 2, 'h00, "R10 write zeros");
    op(0, 2, 0, "R10 lock a held");
    op(0, 0, 0, "R6 idx unchanged");
    lock_in = 2'b10;
    op(0, 2, 0, "R10 lock a clear");
    set_idx('h20D); op(1, 2, 'h00, "R10 write zeros b");
    op(0, 2, 0, "R10 lock b set");
    lock_in = 2'b00;
    op(1, 2, 'hFF, "R10 write ones b");
    op(0, 2, 0, "R10 lock b clear");
    set_idx('h201); op(1, 2, 'hFF, "R10 plain"); op(0, 2, 0, "R10 plain byte");

    // R11: unmapped holes
    set_idx('h02D); op(1, 2, 'h55, "R11 write"); op(0, 2, 0, "R11 hole read");
    set_idx('h100); op(1, 2, 'h66, "R11 write"); op(0, 2, 0, "R11 hole read");
    set_idx('h302); op(1, 2, 'h66, "R11 write"); op(0, 2, 0, "R11 hole read");
    set_idx('h0005); op(0, 2, 0, "R11 neighbour intact");
    idle("R3");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule